// File: doc/BRIEF.md
# Configuration Cycle Routing Decoder

This block sits behind the address/data register pair that software uses to make PCI configuration requests. It keeps the address register. That register is written only by full doubleword writes. When a data-port access arrives, the block decodes the address. It then decides where the request goes: one of the on-chip devices on bus 0, a Type 0 or Type 1 cycle on the downstream PCI Express port, or a Type 0 or Type 1 cycle forwarded to the secondary chip interface.

The routing test uses three inputs:
- the per-device enable bits,
- the port's secondary bus number,
- the port's subordinate bus number.

A request on the secondary bus that names a device other than 0 cannot reach a real target. The block marks it as a master abort. Reads of such a request return all ones and writes are dropped. When the address register's enable bit is clear, the access is not a configuration cycle, and the block reports a pass-through to ordinary I/O decode.

The decision is registered. It appears one clock after the request strobe, together with the forwarded address, write data and write enable.

Top module: `cfg_route_top`

## Requirements
- R1: The address register loads only on a write with all four byte enables set (4'hF). A write with any byte enable clear leaves the register unchanged, and later decodes still use the old value.
- R2: If address bit 31 is clear, the response routes to pass-through (route_o bit 0). In that case fwd_addr_o is zero and fwd_we_o is low.
- R3: Bus 0, device 0, function 0 is always claimed internally (route_o bit 1).
- R4: On bus 0, devices 1, 2 and 4 are claimed internally only when their dev_en_i bit is set and the function is 0. Any other bus-0 request is forwarded as Type 0 on the secondary interface (route_o bit 4).
- R5: If dev_en_i[1] is set, bus equals sec_bus_i and device is 0, the request routes to a port Type 0 cycle (route_o bit 2).
- R6: If dev_en_i[1] is set and sec_bus_i < bus <= sub_bus_i, the request routes to a port Type 1 cycle (route_o bit 3).
- R7: A nonzero bus outside the port window, or any nonzero bus while dev_en_i[1] is clear, is forwarded as Type 1 on the secondary interface (route_o bit 5).
- R8: A request on the secondary bus with a nonzero device is handled as a master abort:
  - it routes to route_o bit 5 with abort_o high;
  - a read returns rdata_o = all ones;
  - a write keeps fwd_we_o low.
  In every other case rdata_o is zero.
- R9: rsp_valid_o is high exactly in the cycle after each cycle with req_i high. Whenever rsp_valid_o is high, exactly one route_o bit is set.
- R10: For routed requests, fwd_addr_o carries:
  - bus in bits 23:16;
  - device in bits 15:11;
  - function in bits 10:8;
  - register in bits 7:2;
  - bits 1:0 = 2'b01 for Type 1 routes (bits 3 and 5) and 2'b00 otherwise;
  - upper bits zero.

  fwd_we_o equals req_we_i for routed, non-aborted requests. When fwd_we_o is high, fwd_wdata_o carries the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_wr_i | input | 1 | Write strobe to the address register |
| addr_be_i | input | 4 | Byte enables of that write |
| addr_wdata_i | input | 32 | Address register write data |
| req_i | input | 1 | Data-port access strobe |
| req_we_i | input | 1 | Data-port access is a write |
| req_wdata_i | input | 32 | Data-port write data |
| dev_en_i | input | 5 | Per-device enable, index = device number |
| sec_bus_i | input | 8 | Port secondary bus number |
| sub_bus_i | input | 8 | Port subordinate bus number |
| rsp_valid_o | output | 1 | Registered decision valid |
| route_o | output | 6 | One-hot route: pass, internal, port T0, port T1, fwd T0, fwd T1 |
| abort_o | output | 1 | Master abort |
| fwd_addr_o | output | 32 | Forwarded configuration address |
| fwd_we_o | output | 1 | Forwarded write enable |
| fwd_wdata_o | output | 32 | Forwarded write data |
| rdata_o | output | 32 | All ones on an aborted read, else zero |

## Verification
The assertions check the following on every cycle:
- the one-cycle request-to-response timing and the one-hot route;
- that partial address writes hold the register;
- that pass-through carries no address and no write;
- that aborts stay on the forward Type 1 route with no write;
- the Type 1 encoding in the address low bits.

Only the bench's scenarios can show the routing choices themselves. These are the bus-0 claims that depend on enables and function number, the window edges at the secondary and subordinate numbers, and the fall-back when the port is disabled. The bench checks each against a behavioural model.

// File: rtl/cfg_route_pkg.sv
package cfg_route_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned BUS_W   = 8;
  localparam int unsigned DEV_W   = 5;
  localparam int unsigned FN_W    = 3;
  localparam int unsigned REG_W   = 6;
  localparam int unsigned BE_W    = ADDR_W / 8;
  localparam int unsigned EN_BIT  = 31;
  localparam int unsigned BUS_LSB = 16;
  localparam int unsigned DEV_LSB = 11;
  localparam int unsigned FN_LSB  = 8;
  localparam int unsigned REG_LSB = 2;

  typedef enum logic [2:0] {
    RT_PASS = 3'd0,
    RT_INT  = 3'd1,
    RT_P0   = 3'd2,
    RT_P1   = 3'd3,
    RT_F0   = 3'd4,
    RT_F1   = 3'd5
  } route_e;

  localparam int unsigned NUM_ROUTES = 6;

  typedef struct packed {
    logic             en;
    logic [BUS_W-1:0] bus;
    logic [DEV_W-1:0] dev;
    logic [FN_W-1:0]  fn;
    logic [REG_W-1:0] regn;
  } cfg_addr_t;
endpackage

// File: rtl/cfg_addr_reg.sv
module cfg_addr_reg
  import cfg_route_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output cfg_addr_t         addr_o
);
  logic full_wr;
  assign full_wr = wr_i && (be_i == {BE_W{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
    end else if (full_wr) begin
      addr_o.en   <= wdata_i[EN_BIT];
      addr_o.bus  <= wdata_i[BUS_LSB +: BUS_W];
      addr_o.dev  <= wdata_i[DEV_LSB +: DEV_W];
      addr_o.fn   <= wdata_i[FN_LSB +: FN_W];
      addr_o.regn <= wdata_i[REG_LSB +: REG_W];
    end
  end

  // R1
  a_r1_partial_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && be_i != {BE_W{1'b1}}) |=> $stable(addr_o));
endmodule

// File: rtl/cfg_route_dec.sv
module cfg_route_dec
  import cfg_route_pkg::*;
#(
  parameter int unsigned NUM_DEV    = 5,
  parameter logic [NUM_DEV-1:0] CLAIM_MASK = 5'b10110,
  parameter int unsigned PORT_DEV   = 1
) (
  input  cfg_addr_t          addr_i,
  input  logic [NUM_DEV-1:0] dev_en_i,
  input  logic [BUS_W-1:0]   sec_bus_i,
  input  logic [BUS_W-1:0]   sub_bus_i,
  output route_e             route_o,
  output logic               abort_o,
  output logic [ADDR_W-1:0]  fwd_addr_o
);
  logic [NUM_DEV-1:0] claim_vec;
  logic port_on, in_window, type1;

  // device 0 function 0 is always present
  assign claim_vec[0] = (addr_i.dev == '0) && (addr_i.fn == '0);

  for (genvar g = 1; g < NUM_DEV; g++) begin : g_claim
    if (CLAIM_MASK[g]) begin : g_en
      assign claim_vec[g] = dev_en_i[g] && (addr_i.dev == DEV_W'(g)) && (addr_i.fn == '0);
    end else begin : g_off
      assign claim_vec[g] = 1'b0;
    end
  end

  assign port_on   = dev_en_i[PORT_DEV];
  assign in_window = (addr_i.bus > sec_bus_i) && (addr_i.bus <= sub_bus_i);

  always_comb begin
    route_o = RT_PASS;
    abort_o = 1'b0;
    if (!addr_i.en) begin
      route_o = RT_PASS;
    end else if (addr_i.bus == '0) begin
      route_o = (|claim_vec) ? RT_INT : RT_F0;
    end else if (port_on && addr_i.bus == sec_bus_i) begin
      if (addr_i.dev == '0) begin
        route_o = RT_P0;
      end else begin
        route_o = RT_F1;
        abort_o = 1'b1;
      end
    end else if (port_on && in_window) begin
      route_o = RT_P1;
    end else begin
      route_o = RT_F1;
    end
  end

  assign type1 = (route_o == RT_P1) || (route_o == RT_F1);

  always_comb begin
    fwd_addr_o = '0;
    if (route_o != RT_PASS) begin
      fwd_addr_o = ADDR_W'({addr_i.bus, addr_i.dev, addr_i.fn, addr_i.regn, 1'b0, type1});
    end
  end
endmodule

// File: rtl/cfg_rsp_reg.sv
module cfg_rsp_reg
  import cfg_route_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     wdata_i,
  input  route_e                route_i,
  input  logic                  abort_i,
  input  logic [ADDR_W-1:0]     fwd_addr_i,
  output logic                  valid_o,
  output logic [NUM_ROUTES-1:0] route_o,
  output logic                  abort_o,
  output logic [ADDR_W-1:0]     fwd_addr_o,
  output logic                  fwd_we_o,
  output logic [ADDR_W-1:0]     fwd_wdata_o,
  output logic [ADDR_W-1:0]     rdata_o
);
  logic [NUM_ROUTES-1:0] route_oh;
  logic                  pass;

  assign pass = (route_i == RT_PASS);

  always_comb begin
    route_oh = '0;
    route_oh[route_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      route_o     <= '0;
      abort_o     <= 1'b0;
      fwd_addr_o  <= '0;
      fwd_we_o    <= 1'b0;
      fwd_wdata_o <= '0;
      rdata_o     <= '0;
    end else begin
      valid_o <= req_i;
      if (req_i) begin
        route_o     <= route_oh;
        abort_o     <= abort_i;
        fwd_addr_o  <= fwd_addr_i;
        fwd_we_o    <= we_i && !pass && !abort_i;
        fwd_wdata_o <= wdata_i;
        rdata_o     <= (abort_i && !we_i) ? '1 : '0;
      end else begin
        fwd_we_o    <= 1'b0;
      end
    end
  end

  // R9
  a_r9_one_route: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $countones(route_o) == 1);
  // R8
  a_r8_abort_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && abort_o) |-> (route_o[RT_F1] && !fwd_we_o));
  // R2
  a_r2_pass_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && route_o[RT_PASS]) |-> (!fwd_we_o && fwd_addr_o == '0));
  // R10
  a_r10_type1_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && (route_o[RT_P1] || route_o[RT_F1])) |-> fwd_addr_o[1:0] == 2'b01);
endmodule

// File: rtl/cfg_route_top.sv
module cfg_route_top
  import cfg_route_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        addr_wr_i,
  input  logic [3:0]  addr_be_i,
  input  logic [31:0] addr_wdata_i,
  input  logic        req_i,
  input  logic        req_we_i,
  input  logic [31:0] req_wdata_i,
  input  logic [4:0]  dev_en_i,
  input  logic [7:0]  sec_bus_i,
  input  logic [7:0]  sub_bus_i,
  output logic        rsp_valid_o,
  output logic [5:0]  route_o,
  output logic        abort_o,
  output logic [31:0] fwd_addr_o,
  output logic        fwd_we_o,
  output logic [31:0] fwd_wdata_o,
  output logic [31:0] rdata_o
);
  cfg_addr_t         addr_q;
  route_e            dec_route;
  logic              dec_abort;
  logic [ADDR_W-1:0] dec_fwd_addr;

  cfg_addr_reg u_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (addr_wr_i),
    .be_i    (addr_be_i),
    .wdata_i (addr_wdata_i),
    .addr_o  (addr_q)
  );

  cfg_route_dec #(
    .NUM_DEV    (5),
    .CLAIM_MASK (5'b10110),
    .PORT_DEV   (1)
  ) u_dec (
    .addr_i     (addr_q),
    .dev_en_i   (dev_en_i),
    .sec_bus_i  (sec_bus_i),
    .sub_bus_i  (sub_bus_i),
    .route_o    (dec_route),
    .abort_o    (dec_abort),
    .fwd_addr_o (dec_fwd_addr)
  );

  cfg_rsp_reg u_rsp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .we_i        (req_we_i),
    .wdata_i     (req_wdata_i),
    .route_i     (dec_route),
    .abort_i     (dec_abort),
    .fwd_addr_i  (dec_fwd_addr),
    .valid_o     (rsp_valid_o),
    .route_o     (route_o),
    .abort_o     (abort_o),
    .fwd_addr_o  (fwd_addr_o),
    .fwd_we_o    (fwd_we_o),
    .fwd_wdata_o (fwd_wdata_o),
    .rdata_o     (rdata_o)
  );

  // R9
  a_r9_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);
  a_r9_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o);
  // R2
  a_r2_disabled_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !addr_q.en) |=> route_o[RT_PASS]);
endmodule

// File: tb/sim_cfg_route_top.sv
module sim_cfg_route_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_wr = 1'b0;
  logic [3:0]  addr_be = 4'h0;
  logic [31:0] addr_wdata = '0;
  logic        req = 1'b0;
  logic        req_we = 1'b0;
  logic [31:0] req_wdata = '0;
  logic [4:0]  dev_en = 5'b10110;
  logic [7:0]  sec_bus = 8'd3;
  logic [7:0]  sub_bus = 8'd7;
  logic        rsp_valid, abort, fwd_we;
  logic [5:0]  route;
  logic [31:0] fwd_addr, fwd_wdata, rdata;

  int vectors = 0;
  int errors = 0;
  int cycles = 0;
  logic [31:0] shadow = '0;
  logic prev_req = 1'b0;

  always #5 clk = ~clk;

  cfg_route_top u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .addr_wr_i(addr_wr), .addr_be_i(addr_be), .addr_wdata_i(addr_wdata),
    .req_i(req), .req_we_i(req_we), .req_wdata_i(req_wdata),
    .dev_en_i(dev_en), .sec_bus_i(sec_bus), .sub_bus_i(sub_bus),
    .rsp_valid_o(rsp_valid), .route_o(route), .abort_o(abort),
    .fwd_addr_o(fwd_addr), .fwd_we_o(fwd_we), .fwd_wdata_o(fwd_wdata),
    .rdata_o(rdata)
  );

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    prev_req <= req;
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
      finish_run();
    end
  end

  // R9: rsp_valid must mirror the previous cycle's strobe on every clock
  always @(negedge clk) begin
    if (rst_n) begin
      vectors++;
      if (rsp_valid !== prev_req) begin
        errors++;
        $display("FAIL R9 valid: actual %b expected %b", rsp_valid, prev_req);
      end
    end
  end

  function automatic int model_route(input logic [31:0] a, output bit ab);
    int bus = a[23:16];
    int dev = a[15:11];
    int fn  = a[10:8];
    ab = 0;
    if (!a[31]) return 0;
    if (bus == 0) begin
      if (dev == 0 && fn == 0) return 1;
      if ((dev == 1 || dev == 2 || dev == 4) && dev_en[dev] && fn == 0) return 1;
      return 4;
    end
    if (dev_en[1] && bus == int'(sec_bus)) begin
      if (dev == 0) return 2;
      ab = 1;
      return 5;
    end
    if (dev_en[1] && bus > int'(sec_bus) && bus <= int'(sub_bus)) return 3;
    return 5;
  endfunction

  task automatic wr_addr(input logic [31:0] a, input logic [3:0] be);
    @(negedge clk);
    addr_wr = 1'b1; addr_be = be; addr_wdata = a;
    if (be == 4'hF) shadow = a;
    @(negedge clk);
    addr_wr = 1'b0;
  endtask

  task automatic access(input bit we, input logic [31:0] wd, input string tag);
    bit ab;
    int r;
    logic [5:0]  e_route;
    logic [31:0] e_addr, e_rdata;
    logic        e_we;
    r = model_route(shadow, ab);
    e_route = 6'd1 << r;
    e_addr = (r == 0) ? 32'h0 : {8'h00, shadow[23:2], 1'b0, (r == 3 || r == 5)};
    e_we = we && (r != 0) && !ab;
    e_rdata = (ab && !we) ? 32'hFFFF_FFFF : 32'h0;
    req = 1'b1; req_we = we; req_wdata = wd;
    @(negedge clk);
    req = 1'b0; req_we = 1'b0;
    vectors++;
    if (route !== e_route || abort !== ab || fwd_addr !== e_addr || fwd_we !== e_we ||
        rdata !== e_rdata || (e_we && fwd_wdata !== wd)) begin
      errors++;
      $display("FAIL %s: actual route=%b ab=%b addr=%h we=%b rd=%h expected route=%b ab=%b addr=%h we=%b rd=%h",
               tag, route, abort, fwd_addr, fwd_we, rdata, e_route, ab, e_addr, e_we, e_rdata);
    end
  endtask

  function automatic logic [31:0] mk(input bit en, input int bus, input int dev,
                                     input int fn, input int rg);
    return {en, 7'h0, 8'(bus), 5'(dev), 3'(fn), 6'(rg), 2'b00};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    vectors++;
    if (rsp_valid !== 1'b0 || route !== 6'h0 || fwd_we !== 1'b0) begin
      errors++;
      $display("FAIL reset: actual v=%b route=%b expected v=0 route=000000", rsp_valid, route);
    end
    rst_n = 1'b1;

    // R3
    wr_addr(mk(1, 0, 0, 0, 4), 4'hF); access(0, 0, "R3 bus0 dev0");
    // R4
    wr_addr(mk(1, 0, 0, 1, 4), 4'hF); access(0, 0, "R4 dev0 fn1");
    for (int d = 1; d < 6; d++) begin
      wr_addr(mk(1, 0, d, 0, 9), 4'hF); access(1, 32'hA5A5_0000 + d, "R4 bus0 dev");
    end
    wr_addr(mk(1, 0, 1, 2, 1), 4'hF); access(0, 0, "R4 dev1 fn2");
    dev_en = 5'b10010;
    wr_addr(mk(1, 0, 2, 0, 1), 4'hF); access(0, 0, "R4 dev2 disabled");
    dev_en = 5'b10110;
    // R5 / R8
    wr_addr(mk(1, 3, 0, 5, 2), 4'hF); access(1, 32'h1234_5678, "R5 sec bus dev0");
    wr_addr(mk(1, 3, 7, 0, 2), 4'hF); access(0, 0, "R8 abort read");
    access(1, 32'hDEAD_BEEF, "R8 abort write");
    // R6 / R7 / R10 window edges
    for (int b = 1; b < 10; b++) begin
      wr_addr(mk(1, b, 0, 1, 63), 4'hF); access(b[0], 32'h0000_0100 + b, "R6 R7 R10 window");
    end
    sub_bus = 8'd2;  // empty window
    wr_addr(mk(1, 4, 0, 0, 0), 4'hF); access(0, 0, "R7 empty window");
    sub_bus = 8'd7;
    dev_en = 5'b10100;  // port disabled
    wr_addr(mk(1, 3, 0, 0, 0), 4'hF); access(0, 0, "R7 port off sec");
    wr_addr(mk(1, 5, 3, 0, 0), 4'hF); access(1, 32'h55, "R7 port off win");
    dev_en = 5'b10110;
    // R2
    wr_addr(mk(0, 0, 0, 0, 0), 4'hF); access(0, 0, "R2 disabled read");
    access(1, 32'h77, "R2 disabled write");
    // R1: partial writes must not change the register
    wr_addr(mk(1, 4, 0, 0, 3), 4'hF);
    wr_addr(mk(0, 0, 0, 0, 0), 4'h7);
    wr_addr(mk(0, 0, 0, 0, 0), 4'h8);
    access(0, 0, "R1 partial ignored");
    // R9: address write with no request gives no response
    wr_addr(mk(1, 0, 0, 0, 0), 4'hF);
    repeat (3) @(negedge clk);
    access(0, 0, "R9 after idle");
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule